// File: doc/BRIEF.md
# SPI Target Port with High-Impedance Data Return

This block is the target (slave) side of a four-wire SPI link. It runs entirely on the system clock. The serial clock, the controller-to-target data line and the active-low select each pass through a synchronizer. Edges of the serial clock are then found in the system clock domain, so the system clock must run at least four times faster than the serial clock. Clock polarity, clock phase and bit order are static configuration pins. They may be changed only while the target is deselected.

On the local side, a transmit word is written into a holding register with a one-cycle load strobe. The shifter takes its next word from that register at every word boundary. Each word that is fully received appears on `rx_data` with a level `rx_valid`, which stays up until the local logic pulses `rx_ack`. If a word finishes while the previous one is still unacknowledged, the new word is discarded and a sticky overrun flag is raised. The target drives its return data line only while it is selected. At all other times the line is released to high impedance so that other targets can share it. An enable output reports when the line is driven.

Top module: `spi_target`

## Requirements
- R1: While the synchronized select is high, `spi_miso_oe` is 0, `spi_miso` is high impedance, and toggles on `spi_sclk` and `spi_mosi` neither complete a word nor disturb the next selected transfer.
- R2: When phase is 0, the first bit of the held transmit word is on `spi_miso` within four system clocks after select falls, before any serial clock edge.
- R3: The edges follow the mode pair (polarity, phase). Mode (0,0) samples on rising and shifts on falling. Mode (0,1) shifts on rising and samples on falling. Mode (1,0) samples on falling and shifts on rising. Mode (1,1) shifts on falling and samples on rising.
- R4: Each serial clock cycle moves one bit in each direction. After DATA_W sample edges, `rx_valid` is set with the full word.
- R5: With `cfg_lsb_first`=0, bit DATA_W-1 goes first in both directions. With `cfg_lsb_first`=1, bit 0 goes first in both directions.
- R6: `rx_valid` and `rx_data` hold steady until an `rx_ack` pulse, and `rx_valid` falls on the clock after that pulse.
- R7: If a word completes while `rx_valid` is 1 and `rx_ack` is 0, the word is dropped, `rx_data` is kept, and `rx_overrun` is set. `rx_overrun` then stays 1 until `ovr_clear` is pulsed.
- R8: Raising select part-way through a word discards the partial bits and restarts the bit count. The next selected transfer starts again from bit 0 of the held transmit word.
- R9: While select stays low, the word after each boundary is reloaded from the holding register. The holding register may be rewritten while the previous word is shifting.
- R10: After reset, `spi_miso_oe`, `rx_valid` and `rx_overrun` are all 0.
- R11: An `rx_ack` in the same cycle as a word completion accepts the new word without overrun. An `ovr_clear` in the same cycle as a new overrun leaves `rx_overrun` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| spi_sclk | input | 1 | Serial clock from controller |
| spi_mosi | input | 1 | Controller-to-target data |
| spi_csn | input | 1 | Active-low target select |
| spi_miso | output | 1 | Target-to-controller data, high impedance when deselected |
| spi_miso_oe | output | 1 | High while `spi_miso` is driven |
| tx_data | input | DATA_W | Next transmit word |
| tx_load | input | 1 | Writes `tx_data` into the holding register |
| rx_data | output | DATA_W | Last accepted received word |
| rx_valid | output | 1 | Received word pending |
| rx_ack | input | 1 | Consumes the pending word |
| rx_overrun | output | 1 | Sticky flag for a dropped word |
| ovr_clear | input | 1 | Clears `rx_overrun` |

## Verification
Word completion can fall in the same system clock as either an `rx_ack` or an `ovr_clear` pulse. Both collisions are provoked by leaving a first word unacknowledged and then timing the pulse from the final sample edge of a second word, counting the synchronizer and edge-detect stages. An acknowledge that lands in that cycle must leave the second word in `rx_data` with no overrun. A clear that lands in that cycle must leave the flag set with the first word kept. A pulse one cycle late would show the opposite result in either case.

// File: rtl/spi_tgt_pkg.sv
package spi_tgt_pkg;

  // Depth of every input synchronizer chain
  localparam int unsigned SYNC_STAGES = 2;

  // Per-cycle events derived from the synchronized serial pins
  typedef struct packed {
    logic sel;        // target selected this cycle
    logic sel_start;  // first cycle of a selection
    logic sample;     // capture the incoming data bit
    logic shift;      // advance the outgoing data bit
  } spi_tgt_evt_t;

endpackage

// File: rtl/spi_tgt_sync.sv
module spi_tgt_sync #(
  parameter int unsigned    N       = 3,
  parameter int unsigned    STAGES  = spi_tgt_pkg::SYNC_STAGES,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], d[b]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= {STAGES{RST_VAL[b]}};
      end else begin
        chain_q <= chain_d;
      end
    end

    assign q[b] = chain_q[STAGES-1];
  end

endmodule

// File: rtl/spi_tgt_edge.sv
module spi_tgt_edge
  import spi_tgt_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpol,
  input  logic         cpha,
  input  logic         sclk_s,
  input  logic         csn_s,
  output spi_tgt_evt_t evt
);

  logic sclk_q;
  logic csn_q;
  logic rise;
  logic fall;
  logic lead;
  logic trail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      csn_q  <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      csn_q  <= csn_s;
    end
  end

  always_comb begin
    rise  = sclk_s & ~sclk_q;
    fall  = ~sclk_s & sclk_q;
    // leading edge leaves the idle level, trailing edge returns to it
    lead  = cpol ? fall : rise;
    trail = cpol ? rise : fall;

    evt.sel       = ~csn_s;
    evt.sel_start = csn_q & ~csn_s;
    evt.sample    = ~csn_s & (cpha ? trail : lead);
    evt.shift     = ~csn_s & (cpha ? lead : trail);
  end

endmodule

// File: rtl/spi_tgt_shift.sv
module spi_tgt_shift
  import spi_tgt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  spi_tgt_evt_t evt,
  input  logic         cpha,
  input  logic         lsb_first,
  input  logic         mosi_s,
  input  logic [W-1:0] load_word,
  output logic         miso_bit,
  output logic         done,
  output logic [W-1:0] word
);

  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [W-1:0]     tx_q, tx_d;
  logic [W-1:0]     rx_q, rx_d;
  logic [W-1:0]     rx_next;
  logic             pend_q, pend_d;
  logic             reg_en;

  always_comb begin
    rx_next = lsb_first ? {mosi_s, rx_q[W-1:1]} : {rx_q[W-2:0], mosi_s};
    cnt_d   = cnt_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    pend_d  = pend_q;
    done    = 1'b0;

    if (!evt.sel) begin
      // deselected: abandon any partial word
      cnt_d  = '0;
      pend_d = 1'b0;
    end else if (evt.sel_start) begin
      cnt_d = '0;
      if (cpha) begin
        pend_d = 1'b1;          // first leading edge presents bit 0
      end else begin
        tx_d   = load_word;     // bit 0 visible before any clock edge
        pend_d = 1'b0;
      end
    end else begin
      if (evt.sample) begin
        rx_d = rx_next;
        if (cnt_q == LAST_IDX) begin
          cnt_d  = '0;
          done   = 1'b1;
          pend_d = 1'b1;        // next shift edge starts a new word
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      if (evt.shift) begin
        if (pend_q) begin
          tx_d   = load_word;
          pend_d = 1'b0;
        end else begin
          tx_d = lsb_first ? {1'b0, tx_q[W-1:1]} : {tx_q[W-2:0], 1'b0};
        end
      end
    end
  end

  assign reg_en = evt.sel | (cnt_q != '0) | pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      pend_q <= 1'b0;
    end else if (reg_en) begin
      cnt_q  <= cnt_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      pend_q <= pend_d;
    end
  end

  assign miso_bit = lsb_first ? tx_q[0] : tx_q[W-1];
  assign word     = rx_next;

  AST_DESEL_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.sel |=> (cnt_q == '0)); // R8

  AST_FIRST_BIT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.sel_start && !cpha) |=>
      (miso_bit == (lsb_first ? $past(load_word[0]) : $past(load_word[W-1])))); // R2

endmodule

// File: rtl/spi_target.sv
module spi_target
  import spi_tgt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic              cfg_lsb_first,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_csn,
  output logic              spi_miso,
  output logic              spi_miso_oe,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_load,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ack,
  output logic              rx_overrun,
  input  logic              ovr_clear
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sn = rst_pipe_q[1];

  // pin synchronizers: {csn, mosi, sclk}, select resets inactive
  logic [2:0]   pins_s;
  spi_tgt_evt_t evt;

  spi_tgt_sync #(
    .N       (3),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({spi_csn, spi_mosi, spi_sclk}),
    .q     (pins_s)
  );

  spi_tgt_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_sn),
    .cpol   (cfg_cpol),
    .cpha   (cfg_cpha),
    .sclk_s (pins_s[0]),
    .csn_s  (pins_s[2]),
    .evt    (evt)
  );

  // transmit holding register
  logic [DATA_W-1:0] tx_hold_q;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      tx_hold_q <= '0;
    end else if (tx_load) begin
      tx_hold_q <= tx_data;
    end
  end

  logic              miso_bit;
  logic              word_done;
  logic [DATA_W-1:0] word_rx;

  spi_tgt_shift #(
    .W (DATA_W)
  ) u_shift (
    .clk       (clk),
    .rst_n     (rst_sn),
    .evt       (evt),
    .cpha      (cfg_cpha),
    .lsb_first (cfg_lsb_first),
    .mosi_s    (pins_s[1]),
    .load_word (tx_hold_q),
    .miso_bit  (miso_bit),
    .done      (word_done),
    .word      (word_rx)
  );

  // receive hand-off
  logic accept;
  logic drop;
  logic valid_d;
  logic ovr_d;

  always_comb begin
    accept  = word_done & (~rx_valid | rx_ack);
    drop    = word_done & rx_valid & ~rx_ack;
    valid_d = accept ? 1'b1 : (rx_ack ? 1'b0 : rx_valid);
    ovr_d   = drop ? 1'b1 : (ovr_clear ? 1'b0 : rx_overrun);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rx_valid   <= 1'b0;
      rx_overrun <= 1'b0;
    end else begin
      rx_valid   <= valid_d;
      rx_overrun <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      rx_data <= '0;
    end else if (accept) begin
      rx_data <= word_rx;
    end
  end

  // return line: driven only while selected
  assign spi_miso_oe = evt.sel;
  assign spi_miso    = evt.sel ? miso_bit : 1'bz;

  AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!rst_sn)
    (rx_valid && !rx_ack) |=> (rx_valid && $stable(rx_data))); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
    (rx_ack && !word_done) |=> !rx_valid); // R6

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_sn)
    (rx_overrun && !ovr_clear) |=> rx_overrun); // R7

  AST_OVR_ON_DROP: assert property (@(posedge clk) disable iff (!rst_sn)
    (word_done && rx_valid && !rx_ack) |=> (rx_overrun && $stable(rx_data))); // R7

  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    !spi_miso_oe |-> !word_done); // R1

endmodule

// File: tb/spi_target_bench.sv
module spi_target_bench;

  localparam int W    = 8;
  localparam int HALF = 8;   // system clocks per serial half period

  typedef struct packed {
    logic         cpol;
    logic         cpha;
    logic         lsb;
    logic [W-1:0] stx;   // word the target sends
    logic [W-1:0] mtx;   // word the controller sends
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    '{1'b0, 1'b1, 1'b0, 8'h5A, 8'hC3},
    '{1'b1, 1'b0, 1'b0, 8'h81, 8'h7E},
    '{1'b1, 1'b1, 1'b0, 8'h96, 8'h69},
    '{1'b0, 1'b0, 1'b1, 8'h01, 8'h80},
    '{1'b0, 1'b1, 1'b1, 8'hF0, 8'h0F},
    '{1'b1, 1'b0, 1'b1, 8'h2D, 8'hD2},
    '{1'b1, 1'b1, 1'b1, 8'h17, 8'hE8}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_cpol, cfg_cpha, cfg_lsb_first;
  logic         spi_sclk, spi_mosi, spi_csn;
  logic         spi_miso, spi_miso_oe;
  logic [W-1:0] tx_data;
  logic         tx_load;
  logic [W-1:0] rx_data;
  logic         rx_valid;
  logic         rx_ack;
  logic         rx_overrun;
  logic         ovr_clear;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  logic [15:0] s_word;
  bit          oe_ok;
  bit          seen_bad;

  always #5 clk = ~clk;

  spi_target #(.DATA_W(W)) u_spi_target (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_cpol      (cfg_cpol),
    .cfg_cpha      (cfg_cpha),
    .cfg_lsb_first (cfg_lsb_first),
    .spi_sclk      (spi_sclk),
    .spi_mosi      (spi_mosi),
    .spi_csn       (spi_csn),
    .spi_miso      (spi_miso),
    .spi_miso_oe   (spi_miso_oe),
    .tx_data       (tx_data),
    .tx_load       (tx_load),
    .rx_data       (rx_data),
    .rx_valid      (rx_valid),
    .rx_ack        (rx_ack),
    .rx_overrun    (rx_overrun),
    .ovr_clear     (ovr_clear)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int bidx(input int i);
    int pos = i % W;
    return (i / W) * W + (cfg_lsb_first ? pos : W - 1 - pos);
  endfunction

  task automatic set_mode(input logic pol, input logic pha, input logic lsb);
    @(negedge clk);
    cfg_cpol      = pol;
    cfg_cpha      = pha;
    cfg_lsb_first = lsb;
    spi_sclk      = pol;
    repeat (4) @(negedge clk);
  endtask

  task automatic load_tx(input logic [W-1:0] w);
    @(negedge clk);
    tx_data = w;
    tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk) rx_ack = 1'b1;
    @(negedge clk) rx_ack = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) ovr_clear = 1'b1;
    @(negedge clk) ovr_clear = 1'b0;
  endtask

  // half period after a sample edge; kind 1/2 lands ack/clear on the completion cycle
  task automatic sample_tail(input bit last, input int kind);
    if (last && kind != 0) begin
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      if (kind == 1) rx_ack = 1'b1; else ovr_clear = 1'b1;
      @(negedge clk);
      rx_ack    = 1'b0;
      ovr_clear = 1'b0;
      repeat (HALF - 2) @(negedge clk);
    end else begin
      repeat (HALF) @(negedge clk);
    end
  endtask

  // controller model; called at a negedge
  task automatic xfer(input logic [15:0] m, input int nbits, input int kind);
    s_word = '0;
    oe_ok  = 1'b1;
    @(negedge clk);
    spi_csn = 1'b0;
    if (!cfg_cpha) spi_mosi = m[bidx(0)];
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (!cfg_cpha) begin
        s_word[bidx(i)] = spi_miso;
        oe_ok = oe_ok & spi_miso_oe;
        spi_sclk = ~spi_sclk;
        sample_tail(i == nbits - 1, kind);
        spi_sclk = ~spi_sclk;
        if (i + 1 < nbits) spi_mosi = m[bidx(i + 1)];
        repeat (HALF) @(negedge clk);
      end else begin
        spi_sclk = ~spi_sclk;
        spi_mosi = m[bidx(i)];
        repeat (HALF) @(negedge clk);
        s_word[bidx(i)] = spi_miso;
        oe_ok = oe_ok & spi_miso_oe;
        spi_sclk = ~spi_sclk;
        sample_tail(i == nbits - 1, kind);
      end
    end
    spi_csn = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0;
    spi_sclk = 1'b0; spi_mosi = 1'b0; spi_csn = 1'b1;
    tx_data = '0; tx_load = 1'b0; rx_ack = 1'b0; ovr_clear = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    check(spi_miso_oe == 1'b0, "R10", "oe after reset", 32'(spi_miso_oe), 0);
    check(rx_valid == 1'b0, "R10", "valid after reset", 32'(rx_valid), 0);
    check(rx_overrun == 1'b0, "R10", "overrun after reset", 32'(rx_overrun), 0);

    // R3 R4 R5 (and R2 for phase 0): every mode and both bit orders
    for (int v = 0; v < 8; v++) begin
      set_mode(VECS[v].cpol, VECS[v].cpha, VECS[v].lsb);
      load_tx(VECS[v].stx);
      xfer({8'h00, VECS[v].mtx}, W, 0);
      check(rx_valid == 1'b1, "R4", "valid after word", 32'(rx_valid), 1);
      check(rx_data == VECS[v].mtx, "R3/R5", "received word", 32'(rx_data), 32'(VECS[v].mtx));
      check(s_word[7:0] == VECS[v].stx, VECS[v].cpha ? "R3/R5" : "R2/R3/R5",
            "returned word", 32'(s_word[7:0]), 32'(VECS[v].stx));
      check(oe_ok, "R1", "oe while selected", 32'(oe_ok), 1);
      check(spi_miso_oe == 1'b0, "R1", "oe after deselect", 32'(spi_miso_oe), 0);
      pulse_ack();
      check(rx_valid == 1'b0, "R6", "valid after ack", 32'(rx_valid), 0);
    end

    // R2 directed: first bit present with no serial clock edge
    set_mode(1'b0, 1'b0, 1'b0);
    load_tx(8'h80);
    @(negedge clk) spi_csn = 1'b0;
    repeat (5) @(negedge clk);
    check(spi_miso_oe == 1'b1, "R2", "oe after select", 32'(spi_miso_oe), 1);
    check(spi_miso == 1'b1, "R2", "first bit early", 32'(spi_miso), 1);
    @(negedge clk) spi_csn = 1'b1;
    repeat (4) @(negedge clk);

    // R1 deselected pin activity is ignored
    set_mode(1'b0, 1'b0, 1'b0);
    seen_bad = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      spi_sclk = ~spi_sclk;
      spi_mosi = k[1];
      repeat (HALF / 2) begin
        @(negedge clk);
        if (rx_valid || spi_miso_oe) seen_bad = 1'b1;
      end
    end
    spi_sclk = 1'b0;
    repeat (4) @(negedge clk);
    check(!seen_bad, "R1", "activity while deselected", 32'(seen_bad), 0);
    load_tx(8'hA5);
    xfer(16'h003C, W, 0);
    check(rx_data == 8'h3C, "R1", "word after ignored toggles", 32'(rx_data), 32'h3C);
    check(s_word[7:0] == 8'hA5, "R1", "return after ignored toggles", 32'(s_word[7:0]), 32'hA5);

    // R6 pending word holds without acknowledge
    repeat (40) @(negedge clk);
    check(rx_valid == 1'b1, "R6", "valid held", 32'(rx_valid), 1);
    check(rx_data == 8'h3C, "R6", "data held", 32'(rx_data), 32'h3C);
    pulse_ack();

    // R8 partial word discarded
    set_mode(1'b0, 1'b1, 1'b0);
    load_tx(8'h96);
    xfer(16'h00FF, 3, 0);
    check(rx_valid == 1'b0, "R8", "no word from partial", 32'(rx_valid), 0);
    load_tx(8'h5A);
    xfer(16'h0081, W, 0);
    check(rx_data == 8'h81, "R8", "word after partial", 32'(rx_data), 32'h81);
    check(s_word[7:0] == 8'h5A, "R8", "return restarts at bit 0", 32'(s_word[7:0]), 32'h5A);
    pulse_ack();

    // R9 back-to-back words with reload from the holding register
    set_mode(1'b1, 1'b1, 1'b0);
    load_tx(8'hC3);
    fork
      xfer(16'h4BE1, 2 * W, 0);
      begin
        repeat (6 * HALF) @(negedge clk);
        load_tx(8'h7E);
        while (!rx_valid) @(negedge clk);
        check(rx_data == 8'hE1, "R9", "first of pair", 32'(rx_data), 32'hE1);
        pulse_ack();
      end
    join
    check(rx_data == 8'h4B, "R9", "second of pair", 32'(rx_data), 32'h4B);
    check(s_word[7:0] == 8'hC3, "R9", "first return", 32'(s_word[7:0]), 32'hC3);
    check(s_word[15:8] == 8'h7E, "R9", "reloaded return", 32'(s_word[15:8]), 32'h7E);
    pulse_ack();

    // R7 overrun drops the new word and sticks
    set_mode(1'b0, 1'b0, 1'b0);
    xfer(16'h0011, W, 0);
    xfer(16'h0022, W, 0);
    check(rx_overrun == 1'b1, "R7", "overrun set", 32'(rx_overrun), 1);
    check(rx_data == 8'h11, "R7", "old word kept", 32'(rx_data), 32'h11);
    repeat (20) @(negedge clk);
    check(rx_overrun == 1'b1, "R7", "overrun sticky", 32'(rx_overrun), 1);
    pulse_clr();
    check(rx_overrun == 1'b0, "R7", "overrun cleared", 32'(rx_overrun), 0);
    pulse_ack();

    // R11 acknowledge in the completion cycle accepts the new word
    xfer(16'h0033, W, 0);
    xfer(16'h0044, W, 1);
    check(rx_data == 8'h44, "R11", "ack coincident data", 32'(rx_data), 32'h44);
    check(rx_valid == 1'b1, "R11", "ack coincident valid", 32'(rx_valid), 1);
    check(rx_overrun == 1'b0, "R11", "ack coincident overrun", 32'(rx_overrun), 0);
    pulse_ack();

    // R11 clear in the overrun cycle loses to the new overrun
    xfer(16'h0055, W, 0);
    xfer(16'h0066, W, 2);
    check(rx_overrun == 1'b1, "R11", "clear coincident overrun", 32'(rx_overrun), 1);
    check(rx_data == 8'h55, "R11", "clear coincident data", 32'(rx_data), 32'h55);
    pulse_clr();
    pulse_ack();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule